// File: doc/BRIEF.md
# Predicted Target Address Buffer

This block runs alongside the instruction line buffer of a fetch unit. The instruction line buffer itself is outside the block. For every instruction slot that the line buffer holds, the block keeps the predicted address of the next instruction and a predicted-taken flag. Fetch writes whole groups of four instructions together with a per-slot taken mask and one predicted target. The block keeps only the first predicted-taken slot of a group. Slots behind that slot are dropped, because fetch continues at the target. The block also owns the fetch pointer. After each accepted group, the pointer moves either to the predicted target or to the next sequential group.

When the pipeline core accepts an instruction, the same transfer carries that instruction's predicted next address and taken flag. A not-taken slot carries its own address plus four. One equality test in the decode stage therefore catches both a wrong direction and a wrong target. The decode stage returns the carried prediction and the real next address. If the two differ, the block raises a redirect in that same cycle. It empties all three lines and loads the real address into the fetch pointer on the same edge that corrects the core's program counter. This keeps the misprediction cost at two cycles.

Top module: `pred_target_queue`

## Requirements
- R1: After reset, issueValid and redirect are 0, wrReady is 1 and fetchPc equals the RESET_PC parameter.
- R2: On an accepted group write (wrValid and wrReady both high), fetchPc becomes wrTarget on the next edge if any wrTakenMask bit is set, and fetchPc + 16 otherwise.
- R3: Only the lowest set bit of wrTakenMask counts (bit i is slot i, at address fetchPc + 4*i). Slots above it are never issued, and issuePredTaken is 1 only for that slot.
- R4: Instructions are issued in slot order within a group and in write order across groups, with issuePc equal to the group base plus 4 times the slot index.
- R5: A slot that is not predicted taken is issued with issuePredNext = issuePc + 4. The predicted-taken slot is issued with its group's wrTarget.
- R6: The buffer holds three groups. wrReady is 0 while three groups are held. A group is freed on the edge where its last valid slot is issued, and a write and a free may occur in the same cycle.
- R7: While issueValid is 1 and issueReady is 0, issuePc, issuePredNext and issuePredTaken stay unchanged.
- R8: redirect is 1 in exactly the cycles where resValid is 1 and resPredNext differs from resActualNext. In those cycles wrReady and issueValid are 0.
- R9: On the edge after a redirect cycle, fetchPc equals that cycle's resActualNext, the buffer is empty (issueValid 0) and every stored prediction is discarded. A group presented in the redirect cycle is dropped.
- R10: A resolution with resPredNext equal to resActualNext changes neither fetchPc nor the buffer contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wrValid | input | 1 | Fetch group present |
| wrReady | output | 1 | Group can be accepted this cycle |
| wrTakenMask | input | 4 | Per-slot predicted-taken bits |
| wrTarget | input | 32 | Predicted target of the first taken slot |
| fetchPc | output | 32 | Fetch pointer: base address of the next group |
| issueValid | output | 1 | An instruction prediction is on offer to the core |
| issueReady | input | 1 | Core takes the offered instruction |
| issuePc | output | 32 | Address of the offered instruction |
| issuePredNext | output | 32 | Predicted next address sent with it |
| issuePredTaken | output | 1 | Predicted-taken flag sent with it |
| resValid | input | 1 | Decode stage resolves an instruction |
| resPredNext | input | 32 | Prediction that travelled with that instruction |
| resActualNext | input | 32 | Real next address from decode |
| redirect | output | 1 | Misprediction: flush and reload fetch pointer |

## Verification
The bench targets groups with several taken bits set. A design that ignored the lowest-bit rule would issue slots past a taken branch or pair a target with the wrong slot. It fills all three lines while the core stalls and then drains with a write in the same cycle as the free. A wrong occupancy count here would either overwrite an unissued group or leave wrReady low for good. It also sends a redirect in the same cycle as a group write, with instructions still buffered. A design that let that write through, kept stale predictions, or loaded the fetch pointer a cycle late would show up as an extra issued instruction or a wrong fetchPc on the following edge.

// File: rtl/ptq_pkg.sv
package ptq_pkg;
  // Strobes the control block hands to the datapath
  typedef struct packed {
    logic doWrite;   // store the presented group into wrLine
    logic doFlush;   // misprediction: reload fetch pointer
  } ptqStrobes_t;
endpackage

// File: rtl/ptq_ctrl.sv
module ptq_ctrl
  import ptq_pkg::*;
#(
  parameter int NUM_LINES = 3,
  parameter int SLOTS     = 4,
  localparam int LINE_W   = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1,
  localparam int SLOT_W   = (SLOTS > 1) ? $clog2(SLOTS) : 1,
  localparam int CNT_W    = $clog2(NUM_LINES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wrValid,
  input  logic              issueReady,
  input  logic              mispredict,
  input  logic              rdIsLast,
  output ptqStrobes_t       strobes,
  output logic [LINE_W-1:0] wrLine,
  output logic [LINE_W-1:0] rdLine,
  output logic [SLOT_W-1:0] rdSlot,
  output logic              wrReady,
  output logic              issueValid,
  output logic              redirect
);
  logic [CNT_W-1:0] lineCount;
  logic             full, empty, doWrite, doIssue, doRetire;

  function automatic logic [LINE_W-1:0] stepLine(input logic [LINE_W-1:0] p);
    return (p == LINE_W'(NUM_LINES - 1)) ? '0 : p + LINE_W'(1);
  endfunction

  assign full       = (lineCount == CNT_W'(NUM_LINES));
  assign empty      = (lineCount == '0);
  assign redirect   = mispredict;
  assign wrReady    = !full && !mispredict;
  assign issueValid = !empty && !mispredict;
  assign doWrite    = wrValid && wrReady;
  assign doIssue    = issueValid && issueReady;
  assign doRetire   = doIssue && rdIsLast;

  always_comb begin
    strobes.doWrite = doWrite;
    strobes.doFlush = mispredict;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || mispredict) begin
      lineCount <= '0;
      wrLine    <= '0;
      rdLine    <= '0;
      rdSlot    <= '0;
    end else begin
      if (doWrite) wrLine <= stepLine(wrLine);
      if (doRetire) begin
        rdLine <= stepLine(rdLine);
        rdSlot <= '0;
      end else if (doIssue) begin
        rdSlot <= rdSlot + SLOT_W'(1);
      end
      lineCount <= lineCount + CNT_W'(doWrite) - CNT_W'(doRetire);
    end
  end
endmodule

// File: rtl/ptq_datapath.sv
module ptq_datapath
  import ptq_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int SLOTS       = 4,
  parameter int NUM_LINES   = 3,
  parameter int INSTR_BYTES = 4,
  parameter logic [ADDR_W-1:0] RESET_PC = '0,
  localparam int LINE_W     = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1,
  localparam int SLOT_W     = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  ptqStrobes_t       strobes,
  input  logic [LINE_W-1:0] wrLine,
  input  logic [LINE_W-1:0] rdLine,
  input  logic [SLOT_W-1:0] rdSlot,
  input  logic [SLOTS-1:0]  wrTakenMask,
  input  logic [ADDR_W-1:0] wrTarget,
  input  logic              resValid,
  input  logic [ADDR_W-1:0] resPredNext,
  input  logic [ADDR_W-1:0] resActualNext,
  output logic [ADDR_W-1:0] fetchPc,
  output logic [ADDR_W-1:0] issuePc,
  output logic [ADDR_W-1:0] issuePredNext,
  output logic              issuePredTaken,
  output logic              rdIsLast,
  output logic              mispredict
);
  localparam logic [ADDR_W-1:0] STEP  = ADDR_W'(INSTR_BYTES);
  localparam logic [ADDR_W-1:0] GROUP = ADDR_W'(SLOTS * INSTR_BYTES);

  // One target per line: at most one taken slot survives per group
  logic [ADDR_W-1:0] lineBase      [NUM_LINES];
  logic [ADDR_W-1:0] lineTarget    [NUM_LINES];
  logic              lineHasTaken  [NUM_LINES];
  logic [SLOT_W-1:0] lineTakenSlot [NUM_LINES];
  logic [SLOT_W-1:0] lineLastSlot  [NUM_LINES];
  logic [NUM_LINES-1:0] lineWe;

  logic              hasTakenW;
  logic [SLOT_W-1:0] takenSlotW, lastSlotW;

  // Priority pick of the lowest taken slot
  always_comb begin
    hasTakenW  = |wrTakenMask;
    takenSlotW = '0;
    for (int i = SLOTS - 1; i >= 0; i--) begin
      if (wrTakenMask[i]) takenSlotW = SLOT_W'(i);
    end
    lastSlotW = hasTakenW ? takenSlotW : SLOT_W'(SLOTS - 1);
  end

  genvar g;
  generate
    for (g = 0; g < NUM_LINES; g++) begin : gLineWe
      assign lineWe[g] = strobes.doWrite && (wrLine == LINE_W'(g));
    end
  endgenerate

  always_ff @(posedge clk) begin
    for (int l = 0; l < NUM_LINES; l++) begin
      if (lineWe[l]) begin
        lineBase[l]      <= fetchPc;
        lineTarget[l]    <= wrTarget;
        lineHasTaken[l]  <= hasTakenW;
        lineTakenSlot[l] <= takenSlotW;
        lineLastSlot[l]  <= lastSlotW;
      end
    end
  end

  // Fetch pointer: the flush path has priority over group advance
  always_ff @(posedge clk) begin
    if (!rst_n)                fetchPc <= RESET_PC;
    else if (strobes.doFlush)  fetchPc <= resActualNext;
    else if (strobes.doWrite)  fetchPc <= hasTakenW ? wrTarget : fetchPc + GROUP;
  end

  logic slotTaken;
  always_comb begin
    issuePc        = lineBase[rdLine] + ADDR_W'(rdSlot) * STEP;
    slotTaken      = lineHasTaken[rdLine] && (lineTakenSlot[rdLine] == rdSlot);
    issuePredTaken = slotTaken;
    issuePredNext  = slotTaken ? lineTarget[rdLine] : issuePc + STEP;
    rdIsLast       = (rdSlot == lineLastSlot[rdLine]);
  end

  assign mispredict = resValid && (resPredNext != resActualNext);
endmodule

// File: rtl/pred_target_queue.sv
module pred_target_queue
  import ptq_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int SLOTS       = 4,
  parameter int NUM_LINES   = 3,
  parameter int INSTR_BYTES = 4,
  parameter logic [ADDR_W-1:0] RESET_PC = 32'h0000_1000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wrValid,
  output logic              wrReady,
  input  logic [SLOTS-1:0]  wrTakenMask,
  input  logic [ADDR_W-1:0] wrTarget,
  output logic [ADDR_W-1:0] fetchPc,
  output logic              issueValid,
  input  logic              issueReady,
  output logic [ADDR_W-1:0] issuePc,
  output logic [ADDR_W-1:0] issuePredNext,
  output logic              issuePredTaken,
  input  logic              resValid,
  input  logic [ADDR_W-1:0] resPredNext,
  input  logic [ADDR_W-1:0] resActualNext,
  output logic              redirect
);
  localparam int LINE_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1;
  localparam int SLOT_W = (SLOTS > 1) ? $clog2(SLOTS) : 1;

  ptqStrobes_t       strobes;
  logic [LINE_W-1:0] wrLine, rdLine;
  logic [SLOT_W-1:0] rdSlot;
  logic              rdIsLast, mispredict;

  ptq_ctrl #(.NUM_LINES(NUM_LINES), .SLOTS(SLOTS)) uCtrl (
    .clk(clk), .rst_n(rst_n), .wrValid(wrValid), .issueReady(issueReady),
    .mispredict(mispredict), .rdIsLast(rdIsLast), .strobes(strobes),
    .wrLine(wrLine), .rdLine(rdLine), .rdSlot(rdSlot), .wrReady(wrReady),
    .issueValid(issueValid), .redirect(redirect)
  );

  ptq_datapath #(
    .ADDR_W(ADDR_W), .SLOTS(SLOTS), .NUM_LINES(NUM_LINES),
    .INSTR_BYTES(INSTR_BYTES), .RESET_PC(RESET_PC)
  ) uData (
    .clk(clk), .rst_n(rst_n), .strobes(strobes), .wrLine(wrLine),
    .rdLine(rdLine), .rdSlot(rdSlot), .wrTakenMask(wrTakenMask),
    .wrTarget(wrTarget), .resValid(resValid), .resPredNext(resPredNext),
    .resActualNext(resActualNext), .fetchPc(fetchPc), .issuePc(issuePc),
    .issuePredNext(issuePredNext), .issuePredTaken(issuePredTaken),
    .rdIsLast(rdIsLast), .mispredict(mispredict)
  );
endmodule

// File: rtl/ptq_checker.sv
module ptq_checker #(
  parameter int ADDR_W      = 32,
  parameter int SLOTS       = 4,
  parameter int INSTR_BYTES = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wrValid,
  input logic              wrReady,
  input logic [SLOTS-1:0]  wrTakenMask,
  input logic [ADDR_W-1:0] wrTarget,
  input logic [ADDR_W-1:0] fetchPc,
  input logic              issueValid,
  input logic              issueReady,
  input logic [ADDR_W-1:0] issuePc,
  input logic [ADDR_W-1:0] issuePredNext,
  input logic              issuePredTaken,
  input logic              resValid,
  input logic [ADDR_W-1:0] resActualNext,
  input logic              redirect
);
  AST_FETCH_SEQ_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (wrValid && wrReady && (wrTakenMask == '0)) |=> (fetchPc == $past(fetchPc) + ADDR_W'(SLOTS * INSTR_BYTES))); // R2
  AST_FETCH_TAKEN_JUMP: assert property (@(posedge clk) disable iff (!rst_n)
    (wrValid && wrReady && (wrTakenMask != '0)) |=> (fetchPc == $past(wrTarget))); // R2
  AST_NOT_TAKEN_SEQ: assert property (@(posedge clk) disable iff (!rst_n)
    (issueValid && !issuePredTaken) |-> (issuePredNext == issuePc + ADDR_W'(INSTR_BYTES))); // R5
  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (issueValid && !issueReady && !resValid) |=> (redirect ||
      (issueValid && $stable(issuePc) && $stable(issuePredNext) && $stable(issuePredTaken)))); // R7
  AST_REDIRECT_NEEDS_RES: assert property (@(posedge clk) disable iff (!rst_n)
    redirect |-> resValid); // R8
  AST_REDIRECT_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    redirect |-> (!wrReady && !issueValid)); // R8
  AST_REDIRECT_LOADS_PC: assert property (@(posedge clk) disable iff (!rst_n)
    redirect |=> (fetchPc == $past(resActualNext))); // R9
  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    redirect |=> (!issueValid && (wrReady || redirect))); // R9
  AST_FETCH_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!(wrValid && wrReady) && !redirect) |=> $stable(fetchPc)); // R10
endmodule

bind pred_target_queue ptq_checker #(
  .ADDR_W(ADDR_W), .SLOTS(SLOTS), .INSTR_BYTES(INSTR_BYTES)
) uChk (
  .clk(clk), .rst_n(rst_n), .wrValid(wrValid), .wrReady(wrReady),
  .wrTakenMask(wrTakenMask), .wrTarget(wrTarget), .fetchPc(fetchPc),
  .issueValid(issueValid), .issueReady(issueReady), .issuePc(issuePc),
  .issuePredNext(issuePredNext), .issuePredTaken(issuePredTaken),
  .resValid(resValid), .resActualNext(resActualNext), .redirect(redirect)
);

// File: tb/pred_target_queue_test.sv
module pred_target_queue_test;
  localparam int CLK_PERIOD = 10;
  localparam int LINES = 3;
  localparam int SLOTS = 4;
  localparam logic [31:0] RESET_PC = 32'h0000_1000;

  logic clk = 0, rst_n = 0;
  logic wrValid = 0, issueReady = 0, resValid = 0;
  logic [3:0] wrTakenMask = 0;
  logic [31:0] wrTarget = 0, resPredNext = 0, resActualNext = 0;
  logic wrReady, issueValid, issuePredTaken, redirect;
  logic [31:0] fetchPc, issuePc, issuePredNext;

  pred_target_queue uut (
    .clk(clk), .rst_n(rst_n), .wrValid(wrValid), .wrReady(wrReady),
    .wrTakenMask(wrTakenMask), .wrTarget(wrTarget), .fetchPc(fetchPc),
    .issueValid(issueValid), .issueReady(issueReady), .issuePc(issuePc),
    .issuePredNext(issuePredNext), .issuePredTaken(issuePredTaken),
    .resValid(resValid), .resPredNext(resPredNext),
    .resActualNext(resActualNext), .redirect(redirect)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  int checks = 0, fails = 0;
  bit done = 0;

  // Reference model state
  logic [31:0] mPc[$], mNext[$];
  bit mTak[$], mLast[$];
  int mLines = 0;
  logic [31:0] mFetch = RESET_PC;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // Compare every output with the model, then advance the model one edge
  task automatic step();
    bit redE, ivE, wrE;
    #1;
    redE = resValid && (resPredNext != resActualNext);
    ivE  = (mPc.size() > 0) && !redE;
    wrE  = (mLines < LINES) && !redE;
    check("R8 redirect", redirect, redE);
    check("R6 wrReady", wrReady, wrE);
    check("R4 issueValid", issueValid, ivE);
    check("R2 R9 R10 fetchPc", fetchPc, mFetch);
    if (ivE) begin
      check("R4 issuePc", issuePc, mPc[0]);
      check("R5 issuePredNext", issuePredNext, mNext[0]);
      check("R3 issuePredTaken", issuePredTaken, mTak[0]);
    end
    @(posedge clk);
    if (redE) begin
      mPc.delete(); mNext.delete(); mTak.delete(); mLast.delete();
      mLines = 0;
      mFetch = resActualNext;
    end else begin
      if (ivE && issueReady) begin
        if (mLast[0]) mLines--;
        void'(mPc.pop_front()); void'(mNext.pop_front());
        void'(mTak.pop_front()); void'(mLast.pop_front());
      end
      if (wrValid && wrE) begin
        for (int i = 0; i < SLOTS; i++) begin
          bit tk, lst;
          tk  = wrTakenMask[i];
          lst = tk || (i == SLOTS - 1);
          mPc.push_back(mFetch + 32'(4 * i));
          mNext.push_back(tk ? wrTarget : mFetch + 32'(4 * i + 4));
          mTak.push_back(tk);
          mLast.push_back(lst);
          if (lst) break;
        end
        mLines++;
        mFetch = (wrTakenMask != 0) ? wrTarget : mFetch + 32'd16;
      end
    end
    @(negedge clk);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    logic [31:0] heldPc, heldNext;
    logic [3:0] masks [5];
    masks[0] = 4'b0100; masks[1] = 4'b1010; masks[2] = 4'b0001;
    masks[3] = 4'b1000; masks[4] = 4'b0000;

    // Reset
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    check("R1 issueValid", issueValid, 0);
    check("R1 wrReady", wrReady, 1);
    check("R1 fetchPc", fetchPc, RESET_PC);
    check("R1 redirect", redirect, 0);
    @(negedge clk);

    // Fill all three lines while the core stalls
    wrValid = 1; wrTakenMask = 0; issueReady = 0;
    repeat (4) step();
    #1 check("R6 full blocks writes", wrReady, 0);
    @(negedge clk);

    // Stall: offered instruction must hold
    wrValid = 0;
    #1 heldPc = issuePc; heldNext = issuePredNext;
    @(negedge clk);
    step(); step();
    #1 check("R7 stalled issuePc", issuePc, heldPc);
    check("R7 stalled issuePredNext", issuePredNext, heldNext);
    @(negedge clk);

    // Drain while writing groups with several taken patterns
    issueReady = 1; wrValid = 1;
    for (int k = 0; k < 30; k++) begin
      wrTakenMask = masks[k % 5];
      wrTarget = 32'h0002_0000 + 32'(k * 32'h40);
      step();
    end
    wrValid = 0; issueReady = 0;
    repeat (2) step();

    // Matching resolution: no effect
    resValid = 1; resPredNext = 32'h1234_5678; resActualNext = 32'h1234_5678;
    #1 check("R10 match gives no redirect", redirect, 0);
    @(negedge clk);
    step();
    // Mismatch with a concurrent group write
    resActualNext = 32'h0000_8000; wrValid = 1; wrTakenMask = 4'b0010;
    wrTarget = 32'h0000_9000;
    step();
    resValid = 0; wrValid = 0;
    #1 check("R9 buffer empty after redirect", issueValid, 0);
    check("R9 fetchPc reloaded", fetchPc, 32'h0000_8000);
    @(negedge clk);

    // Random mix
    for (int k = 0; k < 4000; k++) begin
      wrValid = ($urandom % 3) != 0;
      issueReady = ($urandom % 4) != 0;
      wrTakenMask = (($urandom % 2) == 0) ? 4'b0000 : 4'($urandom);
      wrTarget = {16'h0003, 16'($urandom)} & 32'hFFFF_FFFC;
      resValid = ($urandom % 16) == 0;
      resActualNext = 32'($urandom) & 32'hFFFF_FFFC;
      resPredNext = (($urandom % 2) == 0) ? resActualNext : 32'($urandom);
      step();
    end
    resValid = 0; wrValid = 0;
    step();

    done = 1;
    summary();
    $finish;
  end
endmodule